// File: doc/BRIEF.md
# Extension Unlock and Identification Register File

This block is a compact indexed register file that sits on an 8-bit host I/O bus next to a display controller. The host reaches it through seven ports chosen by `port_sel`: an index and a data port for the sequencer-side register space, an index and a data port for the CRT-side space, two video-enable ports and a setup/ROM-map port. Extended sequencer registers (index 0x80 and above) stay hidden until software writes a magic key to the extension-control register. A fixed version code and an identification register, which reads back the CRT start-address-high register XORed with a constant, let driver software recognise the chip without unlocking anything.

The lock state lives in a two-state machine. `LK_SHUT` is the state after reset. The transition `UNLOCK` (write 0xEA to sequencer index 0x06) moves it to `LK_OPEN`. The transition `RELOCK` (write 0xAE to the same index) moves it back to `LK_SHUT`. Every other access is the self-loop `STAY`. The two video-enable bits are guarded: a write changes them only when the arm bit (bit 7 of compatibility-control index 0xFC) is set, or while the `setup_mode` input is high. In setup mode the sequencer and CRT ports go silent, and only the two enable ports and the setup/ROM-map port respond.

Top module: `ext_id_regfile`

## Requirements
- R1: After reset `ext_en`, `video_en` and `rdata` are 0, and the arm bit (index 0xFC bit 7) is clear.
- R2: A sequencer data write of 0xEA at index 0x06 sets `ext_en` (`UNLOCK`). A write of 0xAE at that index clears it (`RELOCK`).
- R3: A write of any other value to index 0x06 leaves `ext_en` unchanged.
- R4: A read of sequencer index 0x06 returns `ext_en` in bit 0, with bits 7..1 equal to 0.
- R5: While `ext_en` is 0, sequencer data writes to indices 0x80..0xFF are ignored, and reads of those indices return 0x00.
- R6: When unlocked, index 0x8E reads the parameter `VERSION_CODE` (default 0x70). Writes to that index have no effect.
- R7: Indices 0xB0..0xBF are sixteen independent 8-bit read/write scratch registers, reachable only when unlocked.
- R8: CRT index 0x0C is a plain 8-bit read/write register. CRT index 0x1F is read-only and returns index 0x0C XORed with 0xEA.
- R9: A write to either enable port (codes 4 and 5) loads data bit 0 into that enable bit only if index 0xFC bit 7 is 1 or `setup_mode` is 1. Otherwise the write is ignored.
- R10: While `setup_mode` is 1, the sequencer and CRT ports (codes 0..3) ignore writes and read 0x00. Ports 4, 5 and 6 (setup/ROM map, 8-bit read/write) stay active.
- R11: `video_en` is the OR of the two enable bits, and reads of ports 4 and 5 return the enable bit in bit 0.
- R12: `rdata` takes the selected value at the clock edge on which `rd_en` is sampled high, and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_mode | input | 1 | Setup mode; restricts the active ports |
| port_sel | input | 3 | 0 seq index, 1 seq data, 2 CRT index, 3 CRT data, 4 video enable, 5 alternate video enable, 6 setup/ROM map, 7 none |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the selected port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ext_en | output | 1 | Extended registers unlocked |
| video_en | output | 1 | Video subsystem enabled |

## Verification
The bench probes the lock boundary from both sides. It writes a scratch register while locked, unlocks, and reads it back; a design that leaked the write would return the stale value instead of 0x00. It writes non-key values to the control index in both lock states, which catches a machine that toggles or relocks on any write. It sets the start-address-high register to values whose XOR is easy to tell apart, so a wrong constant or a missing XOR shows up in the identification read. It tries enable writes with the arm bit clear, with it set, and in setup mode without it, and it checks that setup mode silences the sequencer port without disturbing the lock state. A design that honoured writes in setup mode would drop the lock.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        P_SEQ_INDEX = 3'd0,
        P_SEQ_DATA  = 3'd1,
        P_CRT_INDEX = 3'd2,
        P_CRT_DATA  = 3'd3,
        P_VID_EN    = 3'd4,
        P_ALT_VID   = 3'd5,
        P_SETUP_MAP = 3'd6,
        P_NONE      = 3'd7
    } port_e;

    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_e;

    localparam logic [DW-1:0] IDX_EXT_CTRL   = 8'h06;
    localparam logic [DW-1:0] IDX_VERSION    = 8'h8E;
    localparam logic [DW-1:0] IDX_COMPAT     = 8'hFC;
    localparam logic [DW-1:0] CRT_START_HI   = 8'h0C;
    localparam logic [DW-1:0] CRT_ID         = 8'h1F;
    localparam logic [DW-1:0] KEY_UNLOCK     = 8'hEA;
    localparam logic [DW-1:0] KEY_RELOCK     = 8'hAE;
    localparam logic [DW-1:0] ID_XOR_MASK    = 8'hEA;
    localparam int            ARM_BIT        = 7;
endpackage

// File: rtl/xreg_unlock_fsm.sv
module xreg_unlock_fsm
    import xreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [DW-1:0] ctl_data,
    output logic          unlocked
);
    lock_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (ctl_wr && ctl_data == KEY_UNLOCK) state_d = LK_OPEN;
            LK_OPEN: if (ctl_wr && ctl_data == KEY_RELOCK) state_d = LK_SHUT;
            default: state_d = LK_SHUT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN: unlocked = 1'b1;
            default: unlocked = 1'b0;
        endcase
    end

    assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_data == KEY_UNLOCK) |=> unlocked);
    assert_relock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_data == KEY_RELOCK) |=> !unlocked);
    assert_other_value_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr || (ctl_data != KEY_UNLOCK && ctl_data != KEY_RELOCK)) |=> $stable(unlocked));
endmodule

// File: rtl/xreg_scratch_bank.sv
module xreg_scratch_bank
    import xreg_pkg::*;
#(
    parameter int NUM = 16,
    localparam int OFF_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_val
);
    logic [DW-1:0] cell_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q[g] <= '0;
            else if (wr && int'(off) == g)
                cell_q[g] <= wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM; i++)
            if (int'(off) == i) rd_val = cell_q[i];
    end
endmodule

// File: rtl/xreg_arm_gate.sv
module xreg_arm_gate #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] wr_mask,
    input  logic           wbit,
    input  logic           arm,
    input  logic           setup,
    output logic [NUM-1:0] bits
);
    logic [NUM-1:0] bits_q;

    for (genvar g = 0; g < NUM; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_q[g] <= 1'b0;
            else if (wr_mask[g] && (arm || setup))
                bits_q[g] <= wbit;
        end

        assert_unarmed_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_mask[g] && !arm && !setup) |=> $stable(bits_q[g]));
        assert_armed_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_mask[g] && (arm || setup)) |=> (bits_q[g] == $past(wbit)));
    end

    assign bits = bits_q;
endmodule

// File: rtl/ext_id_regfile.sv
module ext_id_regfile
    import xreg_pkg::*;
#(
    parameter logic [7:0] VERSION_CODE = 8'h70,
    parameter logic [7:0] SCRATCH_BASE = 8'hB0,
    parameter int         SCRATCH_N    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_mode,
    input  logic [2:0] port_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       ext_en,
    output logic       video_en
);
    localparam int OFF_W  = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;
    localparam int SCR_LO = int'(SCRATCH_BASE);
    localparam int SCR_HI = SCR_LO + SCRATCH_N;
    localparam int N_EN   = 2;

    port_e port;
    assign port = port_e'(port_sel);

    logic [DW-1:0] seq_idx_q, crt_idx_q, start_hi_q, compat_q, map_q, rdata_q;
    logic [DW-1:0] rd_val, scr_rd, scr_diff;
    logic [OFF_W-1:0] scr_off;
    logic [N_EN-1:0] en_bits, en_wr;
    logic bus_open, seq_data_wr, ctl_wr, ext_wr, in_scratch, unlocked;

    // sequencer and CRT spaces answer only outside setup mode
    assign bus_open    = !setup_mode;
    assign seq_data_wr = wr_en && bus_open && (port == P_SEQ_DATA);
    assign ctl_wr      = seq_data_wr && (seq_idx_q == IDX_EXT_CTRL);
    assign ext_wr      = seq_data_wr && seq_idx_q[DW-1] && unlocked;
    assign in_scratch  = (int'(seq_idx_q) >= SCR_LO) && (int'(seq_idx_q) < SCR_HI);
    assign scr_diff    = seq_idx_q - SCRATCH_BASE;
    assign scr_off     = scr_diff[OFF_W-1:0];

    xreg_unlock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_data (wdata),
        .unlocked (unlocked)
    );

    xreg_scratch_bank #(.NUM(SCRATCH_N)) u_scratch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ext_wr && in_scratch),
        .off    (scr_off),
        .wdata  (wdata),
        .rd_val (scr_rd)
    );

    assign en_wr[0] = wr_en && (port == P_VID_EN);
    assign en_wr[1] = wr_en && (port == P_ALT_VID);

    xreg_arm_gate #(.NUM(N_EN)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (en_wr),
        .wbit    (wdata[0]),
        .arm     (compat_q[ARM_BIT]),
        .setup   (setup_mode),
        .bits    (en_bits)
    );

    // plain storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_idx_q  <= '0;
            crt_idx_q  <= '0;
            start_hi_q <= '0;
            compat_q   <= '0;
            map_q      <= '0;
        end else if (wr_en) begin
            unique case (port)
                P_SEQ_INDEX: if (bus_open) seq_idx_q <= wdata;
                P_CRT_INDEX: if (bus_open) crt_idx_q <= wdata;
                P_CRT_DATA:  if (bus_open && crt_idx_q == CRT_START_HI) start_hi_q <= wdata;
                P_SEQ_DATA:  if (ext_wr && seq_idx_q == IDX_COMPAT) compat_q <= wdata;
                P_SETUP_MAP: map_q <= wdata;
                default: ;
            endcase
        end
    end

    // read selection
    always_comb begin
        rd_val = '0;
        unique case (port)
            P_SEQ_INDEX: rd_val = bus_open ? seq_idx_q : '0;
            P_CRT_INDEX: rd_val = bus_open ? crt_idx_q : '0;
            P_SEQ_DATA: begin
                if (!bus_open)                      rd_val = '0;
                else if (seq_idx_q == IDX_EXT_CTRL) rd_val = {{(DW-1){1'b0}}, unlocked};
                else if (!seq_idx_q[DW-1] || !unlocked) rd_val = '0;
                else if (seq_idx_q == IDX_VERSION)  rd_val = VERSION_CODE;
                else if (seq_idx_q == IDX_COMPAT)   rd_val = compat_q;
                else if (in_scratch)                rd_val = scr_rd;
                else                                rd_val = '0;
            end
            P_CRT_DATA: begin
                if (!bus_open)                      rd_val = '0;
                else if (crt_idx_q == CRT_START_HI) rd_val = start_hi_q;
                else if (crt_idx_q == CRT_ID)       rd_val = start_hi_q ^ ID_XOR_MASK;
                else                                rd_val = '0;
            end
            P_VID_EN:    rd_val = {{(DW-1){1'b0}}, en_bits[0]};
            P_ALT_VID:   rd_val = {{(DW-1){1'b0}}, en_bits[1]};
            P_SETUP_MAP: rd_val = map_q;
            P_NONE:      rd_val = '0;
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign rdata    = rdata_q;
    assign ext_en   = unlocked;
    assign video_en = |en_bits;

    assert_locked_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port == P_SEQ_DATA && seq_idx_q[DW-1] && !unlocked) |=> (rdata == '0));
    assert_id_xor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !setup_mode && port == P_CRT_DATA && crt_idx_q == CRT_ID)
            |=> (rdata == ($past(start_hi_q) ^ ID_XOR_MASK)));
    assert_setup_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && setup_mode && !port_sel[2]) |=> (rdata == '0));
    assert_setup_keeps_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        setup_mode |=> $stable(unlocked));
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    assert_video_or_R11: assert property (@(posedge clk) disable iff (!rst_n)
        video_en == (en_bits[0] || en_bits[1]));
endmodule

// File: tb/ext_id_regfile_bench.sv
module ext_id_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       setup_mode = 1'b0;
    logic [2:0] port_sel = 3'd7;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ext_en, video_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_id_regfile u_ext_id_regfile (
        .clk(clk), .rst_n(rst_n), .setup_mode(setup_mode), .port_sel(port_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .ext_en(ext_en), .video_en(video_en)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] p, input logic [7:0] d);
        @(negedge clk); port_sel = p; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; port_sel = 3'd7;
    endtask

    task automatic bus_rd(input logic [2:0] p, output logic [7:0] d);
        @(negedge clk); port_sel = p; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; port_sel = 3'd7; d = rdata;
    endtask

    task automatic seq_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_wr(3'd0, idx); bus_wr(3'd1, d);
    endtask
    task automatic seq_rd(input logic [7:0] idx, output logic [7:0] d);
        bus_wr(3'd0, idx); bus_rd(3'd1, d);
    endtask
    task automatic crt_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_wr(3'd2, idx); bus_wr(3'd3, d);
    endtask
    task automatic crt_rd(input logic [7:0] idx, output logic [7:0] d);
        bus_wr(3'd2, idx); bus_rd(3'd3, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 ext_en", {7'b0, ext_en}, 8'h00);
        chk("R1 video_en", {7'b0, video_en}, 8'h00);
        seq_rd(8'h06, v); chk("R1 R4 lock status", v, 8'h00);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        seq_wr(8'hB3, 8'h5A);
        seq_rd(8'hB3, v); chk("R5 locked scratch read", v, 8'h00);
        seq_rd(8'h8E, v); chk("R5 locked version read", v, 8'h00);
        seq_wr(8'h06, 8'hEA);
        seq_rd(8'hB3, v); chk("R5 locked write ignored", v, 8'h00);
        seq_rd(8'hFC, v); chk("R1 arm clear", v, 8'h00);
    endtask

    task automatic t_unlock();
        logic [7:0] v;
        chk("R2 unlock", {7'b0, ext_en}, 8'h01);
        seq_rd(8'h06, v); chk("R4 read unlocked", v, 8'h01);
        seq_wr(8'h06, 8'h55); chk("R3 open hold", {7'b0, ext_en}, 8'h01);
        seq_wr(8'h06, 8'hAE); chk("R2 relock", {7'b0, ext_en}, 8'h00);
        seq_wr(8'h06, 8'h12); chk("R3 shut hold", {7'b0, ext_en}, 8'h00);
        seq_rd(8'h06, v); chk("R4 read locked", v, 8'h00);
        seq_wr(8'h06, 8'hEA); chk("R2 unlock again", {7'b0, ext_en}, 8'h01);
    endtask

    task automatic t_version();
        logic [7:0] v;
        seq_rd(8'h8E, v); chk("R6 version", v, 8'h70);
        seq_wr(8'h8E, 8'h00);
        seq_rd(8'h8E, v); chk("R6 version write ignored", v, 8'h70);
    endtask

    task automatic t_scratch();
        logic [7:0] v;
        for (int i = 0; i < 16; i++) seq_wr(8'hB0 + 8'(i), 8'(i * 17) ^ 8'h3C);
        for (int i = 0; i < 16; i++) begin
            seq_rd(8'hB0 + 8'(i), v);
            chk("R7 scratch", v, 8'(i * 17) ^ 8'h3C);
        end
    endtask

    task automatic t_id();
        logic [7:0] v;
        crt_wr(8'h0C, 8'h55);
        crt_rd(8'h1F, v); chk("R8 id 55", v, 8'hBF);
        crt_rd(8'h0C, v); chk("R8 start hi", v, 8'h55);
        crt_wr(8'h0C, 8'h00);
        crt_wr(8'h1F, 8'h11);
        crt_rd(8'h1F, v); chk("R8 id 00 read-only", v, 8'hEA);
    endtask

    task automatic t_arm();
        logic [7:0] v;
        seq_wr(8'hFC, 8'h00);
        bus_wr(3'd4, 8'h01); chk("R9 unarmed ignored", {7'b0, video_en}, 8'h00);
        bus_rd(3'd4, v); chk("R9 unarmed port", v, 8'h00);
        seq_wr(8'hFC, 8'h80);
        seq_rd(8'hFC, v); chk("R9 compat readback", v, 8'h80);
        bus_wr(3'd4, 8'h01); chk("R9 armed write", {7'b0, video_en}, 8'h01);
        bus_rd(3'd4, v); chk("R11 enable port", v, 8'h01);
        bus_wr(3'd5, 8'h01); bus_wr(3'd4, 8'h00);
        chk("R11 alt keeps video", {7'b0, video_en}, 8'h01);
        bus_rd(3'd5, v); chk("R11 alt port", v, 8'h01);
        bus_wr(3'd5, 8'h00); chk("R11 both off", {7'b0, video_en}, 8'h00);
        seq_wr(8'hFC, 8'h00);
    endtask

    task automatic t_setup();
        logic [7:0] v;
        bus_wr(3'd0, 8'h06);
        setup_mode = 1'b1;
        bus_rd(3'd1, v); chk("R10 seq silent", v, 8'h00);
        bus_wr(3'd1, 8'hAE); chk("R10 lock untouched", {7'b0, ext_en}, 8'h01);
        bus_rd(3'd2, v); chk("R10 crt index silent", v, 8'h00);
        bus_wr(3'd4, 8'h01); chk("R9 setup enable", {7'b0, video_en}, 8'h01);
        bus_wr(3'd6, 8'hA5);
        bus_rd(3'd6, v); chk("R10 map port", v, 8'hA5);
        @(negedge clk); @(negedge clk);
        chk("R12 rdata hold", rdata, 8'hA5);
        setup_mode = 1'b0;
        seq_rd(8'h06, v); chk("R10 after setup", v, 8'h01);
        bus_wr(3'd4, 8'h00); chk("R9 unarmed off ignored", {7'b0, video_en}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_unlock();
        t_version();
        t_scratch();
        t_id();
        t_arm();
        t_setup();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R12 got=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule